// File: doc/BRIEF.md
# Bad-Block-Skipping Flash Image Loader

This block is the control engine that copies a contiguous boot image out of raw NAND flash into memory. Software, or a boot sequencer, gives it a page-aligned byte offset in flash, an image length in bytes and a destination base address, then pulses `start`. The loader works out which erase blocks cover the image. For each block it first asks a marker-read agent for that block's bad-block marker. If the block is bad, the loader skips it and extends the range by one block. If the block is good, the loader asks a page-reader agent for each page, from the current page to the end of the block, and gives it the destination address for each page.

Because every bad block pushes the last block out by one, the image always lands on the requested number of good blocks. The two agents are reached through simple request/acknowledge handshakes. The agents handle all flash timing and error correction. A one-cycle `done` pulse marks completion. `skipped` reports how many blocks were passed over. An offset that is not page-aligned raises `error` and starts nothing.

Top module: `nand_image_loader`

## Requirements
- R1: On an accepted start, the first block is `start_offset >> (PAGE_SH+PPB_SH)`, the final block is `(start_offset + image_size - 1) >> (PAGE_SH+PPB_SH)`, and the first page index is `start_offset[PAGE_SH+PPB_SH-1:PAGE_SH]`.
- R2: The marker of a block is requested, with `mark_block` equal to that block, before any page of that block is requested. Blocks are visited in ascending order.
- R3: A block is bad when the marker value is not all-ones. With `WIDE_BUS=0` only `mark_value[7:0]` is compared against 8'hFF and bits 15:8 are ignored. With `WIDE_BUS=1` all 16 bits are compared against 16'hFFFF.
- R4: A bad block gets no page request. It increments the final-block bound by one and increments `skipped` by one. `skipped` is cleared on an accepted start.
- R5: In a good block, pages are requested from the current page index up to `2**PPB_SH-1` in ascending order. The next block then starts at page 0.
- R6: `page_dest` equals `dest_base` for the first page request and grows by `2**PAGE_SH` after each acknowledged page.
- R7: A request stays high with stable block, page and destination until its acknowledge. It drops in the cycle after the acknowledge. `mark_req` and `page_req` are never high together.
- R8: After the last page of the final block is acknowledged, `done` is high for exactly one cycle and `busy` is low from then on.
- R9: A start whose offset has any of bits `PAGE_SH-1:0` set sets `error`, issues no request and leaves `busy` low. `error` is cleared by the next accepted start.
- R10: A start with `image_size` of 0 (and an aligned offset) gives a `done` pulse with no request.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (sampled while idle) |
| start_offset | input | ADDR_W | Flash byte offset of the image |
| image_size | input | ADDR_W | Image length in bytes |
| dest_base | input | ADDR_W | Destination address of the first page |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last start had an unaligned offset |
| skipped | output | SKIP_W | Bad blocks skipped in the current/last load |
| mark_req | output | 1 | Marker read request |
| mark_block | output | BLK_W | Block whose marker is wanted |
| mark_ack | input | 1 | Marker read complete, `mark_value` valid |
| mark_value | input | 16 | Marker read from the spare area |
| page_req | output | 1 | Page read request |
| page_block | output | BLK_W | Block of the page |
| page_index | output | PPB_SH | Page within the block |
| page_dest | output | ADDR_W | Destination address for the page |
| page_ack | input | 1 | Page read complete |

## Verification
A wrong block or page register is visible at the next request: the request fields differ from what the bench model expects from the offset, size and bad-block map. A wrong final-block bound, or a lost bad-block extension, shows up as a missing or extra request, or as an early or late `done`. Such a fault is caught at the completion of that load at the latest. A destination counter that slips shows on the page request that follows the slip. The bench draws acknowledge latencies from 0 to 2 cycles so that handshake faults appear.

// File: rtl/imgload_pkg.sv
package imgload_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_MARK_ISSUE,
    LD_MARK_WAIT,
    LD_PAGE_ISSUE,
    LD_PAGE_WAIT,
    LD_FINISH
  } ld_state_t;
endpackage

// File: rtl/imgload_addr_split.sv
module imgload_addr_split #(
  parameter int ADDR_W = 32,
  parameter int PAGE_SH = 11,
  parameter int PPB_SH = 6,
  localparam int BLK_SH = PAGE_SH + PPB_SH,
  localparam int BLK_W = ADDR_W - BLK_SH
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] length,
  output logic [BLK_W-1:0]  first_blk,
  output logic [BLK_W-1:0]  final_blk,
  output logic [PPB_SH-1:0] first_pg,
  output logic              aligned,
  output logic              empty
);
  logic [ADDR_W-1:0] end_byte;

  always_comb begin
    end_byte  = offset + length - ADDR_W'(1);
    first_blk = offset[ADDR_W-1:BLK_SH];
    final_blk = end_byte[ADDR_W-1:BLK_SH];
    first_pg  = offset[BLK_SH-1:PAGE_SH];
    aligned   = (offset[PAGE_SH-1:0] == '0);
    empty     = (length == '0);
  end
endmodule

// File: rtl/imgload_marker_check.sv
module imgload_marker_check #(
  parameter bit WIDE_BUS = 1'b0
) (
  input  logic [15:0] value,
  output logic        is_bad
);
  generate
    if (WIDE_BUS) begin : g_wide
      assign is_bad = (value != 16'hFFFF);
    end else begin : g_narrow
      assign is_bad = (value[7:0] != 8'hFF);
    end
  endgenerate
endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader #(
  parameter int ADDR_W = 32,
  parameter int PAGE_SH = 11,
  parameter int PPB_SH = 6,
  parameter int SKIP_W = 8,
  parameter bit WIDE_BUS = 1'b0,
  localparam int BLK_W = ADDR_W - PAGE_SH - PPB_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_offset,
  input  logic [ADDR_W-1:0] image_size,
  input  logic [ADDR_W-1:0] dest_base,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [SKIP_W-1:0] skipped,
  output logic              mark_req,
  output logic [BLK_W-1:0]  mark_block,
  input  logic              mark_ack,
  input  logic [15:0]       mark_value,
  output logic              page_req,
  output logic [BLK_W-1:0]  page_block,
  output logic [PPB_SH-1:0] page_index,
  output logic [ADDR_W-1:0] page_dest,
  input  logic              page_ack
);
  import imgload_pkg::*;

  localparam logic [ADDR_W-1:0] PAGE_STEP = ADDR_W'(1) << PAGE_SH;
  localparam logic [PPB_SH-1:0] PG_LAST = '1;

  ld_state_t         state;
  logic [BLK_W-1:0]  blk_q, bound_q;
  logic [PPB_SH-1:0] pg_q;
  logic [ADDR_W-1:0] dest_q;

  logic [BLK_W-1:0]  c_first, c_final;
  logic [PPB_SH-1:0] c_pg;
  logic              c_aligned, c_empty, marker_bad;

  imgload_addr_split #(.ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .PPB_SH(PPB_SH)) split_i (
    .offset(start_offset), .length(image_size),
    .first_blk(c_first), .final_blk(c_final), .first_pg(c_pg),
    .aligned(c_aligned), .empty(c_empty)
  );

  imgload_marker_check #(.WIDE_BUS(WIDE_BUS)) mchk_i (
    .value(mark_value), .is_bad(marker_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LD_IDLE;
      blk_q    <= '0;
      bound_q  <= '0;
      pg_q     <= '0;
      dest_q   <= '0;
      skipped  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      mark_req <= 1'b0;
      page_req <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        LD_IDLE: begin
          if (start) begin
            if (!c_aligned) begin
              error <= 1'b1;
            end else begin
              error   <= 1'b0;
              busy    <= 1'b1;
              skipped <= '0;
              blk_q   <= c_first;
              bound_q <= c_final;
              pg_q    <= c_pg;
              dest_q  <= dest_base;
              state   <= c_empty ? LD_FINISH : LD_MARK_ISSUE;
            end
          end
        end
        LD_MARK_ISSUE: begin
          mark_req <= 1'b1;
          state    <= LD_MARK_WAIT;
        end
        LD_MARK_WAIT: begin
          if (mark_ack) begin
            mark_req <= 1'b0;
            if (marker_bad) begin
              skipped <= skipped + SKIP_W'(1);
              bound_q <= bound_q + BLK_W'(1);
              blk_q   <= blk_q + BLK_W'(1);
              state   <= LD_MARK_ISSUE;
            end else begin
              state <= LD_PAGE_ISSUE;
            end
          end
        end
        LD_PAGE_ISSUE: begin
          page_req <= 1'b1;
          state    <= LD_PAGE_WAIT;
        end
        LD_PAGE_WAIT: begin
          if (page_ack) begin
            page_req <= 1'b0;
            dest_q   <= dest_q + PAGE_STEP;
            if (pg_q == PG_LAST) begin
              pg_q  <= '0;
              blk_q <= blk_q + BLK_W'(1);
              state <= (blk_q == bound_q) ? LD_FINISH : LD_MARK_ISSUE;
            end else begin
              pg_q  <= pg_q + PPB_SH'(1);
              state <= LD_PAGE_ISSUE;
            end
          end
        end
        LD_FINISH: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= LD_IDLE;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  assign mark_block = blk_q;
  assign page_block = blk_q;
  assign page_index = pg_q;
  assign page_dest  = dest_q;

  // Handshake guards
  assert_one_req_R7: assert property (@(posedge clk) disable iff (rst)
    !(mark_req && page_req));
  assert_mark_hold_R7: assert property (@(posedge clk) disable iff (rst)
    mark_req && !mark_ack |=> mark_req && $stable(mark_block));
  assert_page_hold_R7: assert property (@(posedge clk) disable iff (rst)
    page_req && !page_ack |=> page_req && $stable(page_index) && $stable(page_dest));
  assert_mark_drop_R7: assert property (@(posedge clk) disable iff (rst)
    mark_req && mark_ack |=> !mark_req);

  // Bad block skip
  assert_bad_nopage_R4: assert property (@(posedge clk) disable iff (rst)
    mark_req && mark_ack && marker_bad |=> !page_req && skipped == $past(skipped) + SKIP_W'(1));

  // Destination and page stepping
  assert_dest_step_R6: assert property (@(posedge clk) disable iff (rst)
    page_req && page_ack |=> page_dest == $past(page_dest) + PAGE_STEP);
  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    page_req && page_ack && page_index == PG_LAST |=> page_index == '0);

  // Completion and error
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    error |-> !mark_req && !page_req && !busy);
endmodule

// File: tb/nand_image_loader_tb_top.sv
module nand_image_loader_tb_top;
  localparam int ADDR_W = 16;
  localparam int PAGE_SH = 4;
  localparam int PPB_SH = 2;
  localparam int SKIP_W = 8;
  localparam int BLK_SH = PAGE_SH + PPB_SH;
  localparam int BLK_W = ADDR_W - BLK_SH;
  localparam int PPB = 1 << PPB_SH;
  localparam int PBYTES = 1 << PAGE_SH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_offset = '0, image_size = '0, dest_base = '0;
  logic busy, done, error;
  logic [SKIP_W-1:0] skipped;
  logic mark_req, page_req;
  logic mark_ack = 1'b0, page_ack = 1'b0;
  logic [15:0] mark_value = '0;
  logic [BLK_W-1:0] mark_block, page_block;
  logic [PPB_SH-1:0] page_index;
  logic [ADDR_W-1:0] page_dest;

  always #4 clk = ~clk;

  nand_image_loader #(.ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .PPB_SH(PPB_SH),
                      .SKIP_W(SKIP_W), .WIDE_BUS(1'b0)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_offset(start_offset),
    .image_size(image_size), .dest_base(dest_base), .busy(busy), .done(done),
    .error(error), .skipped(skipped), .mark_req(mark_req), .mark_block(mark_block),
    .mark_ack(mark_ack), .mark_value(mark_value), .page_req(page_req),
    .page_block(page_block), .page_index(page_index), .page_dest(page_dest),
    .page_ack(page_ack)
  );

  int vectors = 0;
  int miscompares = 0;
  bit bad_map [0:1023];

  // expected request stream: kind 0 = marker, 1 = page
  int exp_kind[$];
  int exp_blk[$];
  int exp_pg[$];
  int exp_dst[$];
  int exp_skip;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build_model(input int offs, input int size, input int base);
    int blk, last, pg, dst;
    exp_kind.delete(); exp_blk.delete(); exp_pg.delete(); exp_dst.delete();
    exp_skip = 0;
    if (size == 0) return;
    blk = offs / (PBYTES * PPB);
    last = (offs + size - 1) / (PBYTES * PPB);
    pg = (offs % (PBYTES * PPB)) / PBYTES;
    dst = base;
    while (blk <= last) begin
      exp_kind.push_back(0); exp_blk.push_back(blk); exp_pg.push_back(0); exp_dst.push_back(0);
      if (bad_map[blk]) begin
        last++;
        exp_skip++;
      end else begin
        while (pg < PPB) begin
          exp_kind.push_back(1); exp_blk.push_back(blk); exp_pg.push_back(pg); exp_dst.push_back(dst);
          dst = (dst + PBYTES) & 16'hFFFF;
          pg++;
        end
        pg = 0;
      end
      blk++;
    end
  endtask

  // responder agents with rotating latency 0..2
  int m_lat = 0, m_tgt = 0, p_lat = 0, p_tgt = 1;
  initial begin
    forever begin
      @(negedge clk);
      mark_ack = 1'b0;
      page_ack = 1'b0;
      check(!(mark_req && page_req), "R7 one request", {mark_req, page_req}, 0);
      if (mark_req) begin
        if (m_lat == m_tgt) begin
          check(exp_kind.size() > 0 && exp_kind[0] == 0, "R2 marker order", 0, 0);
          if (exp_kind.size() > 0) begin
            check(int'(mark_block) == exp_blk[0], "R2 mark_block", int'(mark_block), exp_blk[0]);
            // R3: good marker carries 00 in bits 15:8, bad marker 3C in bits 7:0
            mark_value = bad_map[mark_block] ? 16'hFF3C : 16'h00FF;
            void'(exp_kind.pop_front()); void'(exp_blk.pop_front());
            void'(exp_pg.pop_front()); void'(exp_dst.pop_front());
          end
          mark_ack = 1'b1;
          m_lat = 0;
          m_tgt = (m_tgt + 1) % 3;
        end else m_lat++;
      end
      if (page_req) begin
        if (p_lat == p_tgt) begin
          check(exp_kind.size() > 0 && exp_kind[0] == 1, "R4 page kind", 1, 1);
          if (exp_kind.size() > 0) begin
            check(int'(page_block) == exp_blk[0], "R5 page_block", int'(page_block), exp_blk[0]);
            check(int'(page_index) == exp_pg[0], "R5 page_index", int'(page_index), exp_pg[0]);
            check(int'(page_dest) == exp_dst[0], "R6 page_dest", int'(page_dest), exp_dst[0]);
            void'(exp_kind.pop_front()); void'(exp_blk.pop_front());
            void'(exp_pg.pop_front()); void'(exp_dst.pop_front());
          end
          page_ack = 1'b1;
          p_lat = 0;
          p_tgt = (p_tgt + 1) % 3;
        end else p_lat++;
      end
    end
  end

  task automatic run_case(input int offs, input int size, input int base, input bit mid_start);
    bit seen;
    build_model(offs, size, base);
    @(negedge clk);
    start_offset = offs[ADDR_W-1:0];
    image_size = size[ADDR_W-1:0];
    dest_base = base[ADDR_W-1:0];
    start = 1'b1;
    seen = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      // R11: a start while busy must not restart or alter the load
      if (mid_start && n == 6) begin
        start_offset = '0;
        image_size = 16'h0040;
        start = 1'b1;
      end else start = 1'b0;
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    start = 1'b0;
    check(seen, "R8 done seen", seen, 1);
    check(exp_kind.size() == 0, "R2/R5 requests remaining", exp_kind.size(), 0);
    check(int'(skipped) == exp_skip, "R4 skipped", int'(skipped), exp_skip);
    check(!error, "R9 error clear", error, 0);
    @(negedge clk);
    check(!done && !busy, "R8 done one cycle", {done, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    foreach (bad_map[i]) bad_map[i] = 1'b0;
    bad_map[3] = 1'b1;
    bad_map[4] = 1'b1;
    bad_map[7] = 1'b1;
    bad_map[9] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !error && !mark_req && !page_req, "R8 reset state",
          {busy, done, error, mark_req, page_req}, 0);

    // R1 / R5: mid-block start, one good block, pages 1..3
    run_case(16'h0050, 16'h0030, 16'h1000, 1'b0);
    // R1 / R4: span with two consecutive bad blocks, range extends to block 6
    run_case(16'h0080, 16'h00C0, 16'h2000, 1'b0);
    // R2 / R4: first block bad
    run_case(16'h01C0, 16'h0010, 16'h3000, 1'b0);
    // R4 / R11: bad block after a full good block, start pulsed while busy
    run_case(16'h0200, 16'h0080, 16'h4000, 1'b1);

    // R9: unaligned offset
    @(negedge clk);
    start_offset = 16'h0085;
    image_size = 16'h0020;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(error, "R9 error set", error, 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(!busy && !mark_req && !page_req, "R9 no activity", {busy, mark_req, page_req}, 0);
    end

    // R10: zero size, also clears error
    run_case(16'h0040, 16'h0000, 16'h5000, 1'b0);
    // R3 / R6: good run crossing blocks 0..2 with destination wrap near top
    run_case(16'h0000, 16'h00B0, 16'hFFE0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule